// File: doc/BRIEF.md
# Host Bridge Configuration Port Sequencer

This block gives a host bridge the address and data ports that generate PCI configuration cycles, plus a register holding the bridge's own bus number and the highest bus number behind it. All three are reached only through a simple local-bus port with a request/acknowledge handshake. They are never placed in PCI I/O space. Software writes a target (enable, bus, device, function, register number) into the address port. An access to the data port then becomes one configuration transaction on the PCI side.

The target is decoded against the bus register. A bus equal to the bridge's own number gives a type-0 cycle carrying a one-hot device select. A bus above it, up to and including the subordinate number, gives a type-1 cycle. A data-port access keeps the local bus stalled, with the acknowledge held low, until the PCI transaction engine reports completion. Read data, or all ones after a master abort, is then returned. Only one transaction is ever outstanding. A parameter removes the whole register set for bridges without host configuration support.

Top module: `cfg_port_seq`

## Requirements
- R1: After reset, `pci_req` and `lb_ack` are low, the address port (index 0) reads 0, and the bus register (index 2) reads the reset bus numbers with the error flag clear.
- R2: A write to the address port stores bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register). A read returns them with all other bits zero, so a write of 0xFFFFFFFF reads back 0x80FFFFFC. Index 3 reads 0. Every register access is acknowledged one cycle after it is accepted.
- R3: The bus register holds the own bus number in bits 7:0 and the subordinate bus number in bits 15:8, with the sticky error flag readable at bit 16. A write with bit 16 set clears the flag.
- R4: When the enable bit is clear, a data-port access (index 1) starts no PCI cycle and is acknowledged after one cycle. A read returns 0xFFFFFFFF.
- R5: A target bus equal to the own bus number, with device 0 to 20, starts a type-0 cycle (`pci_type1`=0). Its address has bit 11+device set among bits 31:11, the function in 10:8, the register in 7:2, and 00 in bits 1:0.
- R6: A target bus greater than the own number and not above the subordinate number starts a type-1 cycle (`pci_type1`=1). Its address is {8'h00, bus, device, function, register, 2'b01}.
- R7: A device above 20 on the own bus, or a bus outside the range from own to subordinate, starts no PCI cycle. The access is acknowledged after one cycle, a read returns 0xFFFFFFFF, and the error flag is set.
- R8: For a PCI read, `lb_ack` stays low until `pci_done`. It rises one cycle after the cycle in which `pci_done` is high, with `lb_rdata` equal to `pci_rdata`.
- R9: A data-port write starts a cycle with `pci_wr`=1 and `pci_wdata` equal to the local write data. It is acknowledged one cycle after `pci_done`.
- R10: A completion with `pci_mabort` high returns 0xFFFFFFFF to a read and sets the sticky error flag, for both reads and writes.
- R11: `pci_req` rises one cycle after a data-port access is accepted. It stays high, with address, type and direction stable, until `pci_done`. No second local access is accepted meanwhile.
- R12: With `HOST_CFG_EN`=0, every index reads 0 and is acknowledged after one cycle, and `pci_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lb_req | input | 1 | Local access request, held until acknowledged |
| lb_wr | input | 1 | 1 = write, 0 = read |
| lb_idx | input | IDX_W | Register index: 0 address port, 1 data port, 2 bus register |
| lb_wdata | input | 32 | Local write data |
| lb_ack | output | 1 | One-cycle acknowledge |
| lb_rdata | output | 32 | Read data, valid with `lb_ack` |
| pci_req | output | 1 | Configuration transaction request, held until done |
| pci_wr | output | 1 | Transaction is a write |
| pci_type1 | output | 1 | Type-1 (1) or type-0 (0) cycle |
| pci_addr | output | 32 | Configuration address phase value |
| pci_wdata | output | 32 | Configuration write data |
| pci_done | input | 1 | One-cycle completion from the transaction engine |
| pci_rdata | input | 32 | Read data, valid with `pci_done` |
| pci_mabort | input | 1 | Completion ended in master abort |

## Verification
Register accesses, and data-port accesses that complete locally (enable clear, out-of-range target, device above 20), are due exactly one cycle after the accepting edge. A forwarded access raises `pci_req` one cycle after acceptance. The engine model waits a chosen L cycles before pulsing `pci_done`, and the acknowledge then falls due 2+L cycles after acceptance. The bench drives on falling edges, counts rising edges until it sees the acknowledge, and compares that count with the value computed from the decoded target and the chosen L. At the same point it compares the request fields captured by the engine model and the returned data.

// File: rtl/cfg_port_pkg.sv
// Shared types for the configuration port sequencer.
// Assumes 32-bit local data and the standard configuration address layout.
package cfg_port_pkg;
    localparam int DW = 32;
    localparam int T0_MAX_DEV = 20;
    localparam logic [DW-1:0] ALL_ONES = '1;

    // Stored address-port fields, packed in the same bit order as bits 31 and 23:2.
    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] rg;
    } cfg_addr_t;

    typedef enum logic [1:0] {TGT_OFF, TGT_T0, TGT_T1, TGT_ABORT} tgt_kind_t;

    typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_state_t;

    // Rebuild the 32-bit address-port read value, with reserved bits zero.
    function automatic logic [DW-1:0] pack_addr_port(cfg_addr_t a);
        return {a.en, 7'b0, a.bus, a.dev, a.fn, a.rg, 2'b00};
    endfunction
endpackage

// File: rtl/cfg_target_decode.sv
// Decodes the stored address-port fields against the bus range of the bridge.
// Produces the cycle kind and the address-phase value for that kind.
// Assumes: purely combinational; the caller registers the result when issuing.
module cfg_target_decode
    import cfg_port_pkg::*;
(
    input  cfg_addr_t        cur,
    input  logic [7:0]       pri_bus,
    input  logic [7:0]       sub_bus,
    output tgt_kind_t        kind,
    output logic [DW-1:0]    tgt_addr
);
    logic [20:0] idsel;
    logic        on_own_bus;
    logic        below_us;

    // Classify the target and form the address for type-0 or type-1 cycles.
    always_comb begin
        idsel      = 21'd1 << cur.dev;
        on_own_bus = (cur.bus == pri_bus);
        below_us   = (cur.bus > pri_bus) && (cur.bus <= sub_bus);
        if (!cur.en)
            kind = TGT_OFF;
        else if (on_own_bus)
            kind = (cur.dev > 5'(T0_MAX_DEV)) ? TGT_ABORT : TGT_T0;
        else if (below_us)
            kind = TGT_T1;
        else
            kind = TGT_ABORT;
        if (on_own_bus)
            tgt_addr = {idsel, cur.fn, cur.rg, 2'b00};
        else
            tgt_addr = {8'h00, cur.bus, cur.dev, cur.fn, cur.rg, 2'b01};
    end
endmodule

// File: rtl/cfg_port_regs.sv
// Holds the address port, the bus-number register and the sticky error flag.
// Provides the read mux for every index except the data port.
// Assumes: writes arrive as single-cycle strobes from the sequencer.
module cfg_port_regs
    import cfg_port_pkg::*;
#(
    parameter int          IDX_W    = 2,
    parameter logic [7:0]  RST_PRI  = 8'd0,
    parameter logic [7:0]  RST_SUB  = 8'd0,
    parameter int          ADDR_IDX = 0,
    parameter int          BUS_IDX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  cfg_addr_t         wr_fields,
    input  logic [7:0]        wr_pri,
    input  logic [7:0]        wr_sub,
    input  logic              wr_clr,
    input  logic              err_set,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DW-1:0]     rd_data,
    output cfg_addr_t         cur_addr,
    output logic [7:0]        pri_bus,
    output logic [7:0]        sub_bus,
    output logic              err_flag
);
    localparam logic [IDX_W-1:0] A_IDX = IDX_W'(ADDR_IDX);
    localparam logic [IDX_W-1:0] B_IDX = IDX_W'(BUS_IDX);

    logic bus_wr;
    assign bus_wr = wr_en && (wr_idx == B_IDX);

    // Address-port and bus-register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            pri_bus  <= RST_PRI;
            sub_bus  <= RST_SUB;
        end else if (wr_en && wr_idx == A_IDX) begin
            cur_addr <= wr_fields;
        end else if (bus_wr) begin
            pri_bus  <= wr_pri;
            sub_bus  <= wr_sub;
        end
    end

    // Sticky error flag: setting wins over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (err_set)
            err_flag <= 1'b1;
        else if (bus_wr && wr_clr)
            err_flag <= 1'b0;
    end

    // Read mux for the non-data indices.
    always_comb begin
        if (rd_idx == A_IDX)
            rd_data = pack_addr_port(cur_addr);
        else if (rd_idx == B_IDX)
            rd_data = {15'b0, err_flag, sub_bus, pri_bus};
        else
            rd_data = '0;
    end

    // The flag is set in the cycle after an error strobe.
    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err_flag);
    // The flag holds until a clearing write to the bus register.
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(bus_wr && wr_clr)) |=> err_flag);
endmodule

// File: rtl/cfg_cycle_fsm.sv
// Sequences local accesses: answers register accesses in one cycle, completes
// disabled or unreachable data-port accesses locally, and forwards the rest to
// the PCI transaction engine, stalling the local bus until completion.
// Assumes: the local master holds lb_req until lb_ack; pci_done is a one-cycle pulse.
module cfg_cycle_fsm
    import cfg_port_pkg::*;
#(
    parameter int IDX_W    = 2,
    parameter int DATA_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_req,
    input  logic              lb_wr,
    input  logic [IDX_W-1:0]  lb_idx,
    input  logic [DW-1:0]     lb_wdata,
    output logic              lb_ack,
    output logic [DW-1:0]     lb_rdata,
    input  tgt_kind_t         kind,
    input  logic [DW-1:0]     tgt_addr,
    input  logic [DW-1:0]     reg_rdata,
    output logic              reg_wr,
    output logic              err_set,
    output logic              pci_req,
    output logic              pci_wr,
    output logic              pci_type1,
    output logic [DW-1:0]     pci_addr,
    output logic [DW-1:0]     pci_wdata,
    input  logic              pci_done,
    input  logic [DW-1:0]     pci_rdata,
    input  logic              pci_mabort
);
    localparam logic [IDX_W-1:0] D_IDX = IDX_W'(DATA_IDX);

    seq_state_t state;
    logic       accept;
    logic       is_data;
    logic       fwd;

    // Acceptance and the strobes derived from it.
    always_comb begin
        accept  = (state == SEQ_IDLE) && lb_req && !lb_ack;
        is_data = (lb_idx == D_IDX);
        fwd     = (kind == TGT_T0) || (kind == TGT_T1);
        reg_wr  = accept && lb_wr && !is_data;
        err_set = (accept && is_data && kind == TGT_ABORT) ||
                  (state == SEQ_WAIT && pci_done && pci_mabort);
    end

    // Main sequencer: issue, wait, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            lb_ack    <= 1'b0;
            lb_rdata  <= '0;
            pci_req   <= 1'b0;
            pci_wr    <= 1'b0;
            pci_type1 <= 1'b0;
            pci_addr  <= '0;
            pci_wdata <= '0;
        end else begin
            lb_ack <= 1'b0;
            if (accept) begin
                if (!is_data) begin
                    lb_ack   <= 1'b1;
                    lb_rdata <= reg_rdata;
                end else if (fwd) begin
                    pci_req   <= 1'b1;
                    pci_wr    <= lb_wr;
                    pci_type1 <= (kind == TGT_T1);
                    pci_addr  <= tgt_addr;
                    pci_wdata <= lb_wdata;
                    state     <= SEQ_WAIT;
                end else begin
                    lb_ack   <= 1'b1;
                    lb_rdata <= ALL_ONES;
                end
            end else if (state == SEQ_WAIT && pci_done) begin
                pci_req  <= 1'b0;
                lb_ack   <= 1'b1;
                lb_rdata <= (pci_mabort || pci_wr) ? ALL_ONES : pci_rdata;
                state    <= SEQ_IDLE;
            end
        end
    end

    // Request and its fields stay put until completion.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && !pci_done) |=> (pci_req && $stable(pci_addr) &&
                                    $stable(pci_wr) && $stable(pci_type1)));
    // No acknowledge while a transaction is pending.
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req |-> !lb_ack);
    // Completion produces the acknowledge in the next cycle.
    p_done_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && pci_done) |=> (lb_ack && !pci_req));
    // Acknowledge is a single-cycle pulse.
    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ack |=> !lb_ack);
    // Type-1 address phase ends in 01.
    p_t1_fmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && pci_type1) |-> (pci_addr[1:0] == 2'b01));
    // Type-0 address phase has exactly one select bit and ends in 00.
    p_t0_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && !pci_type1) |->
            (pci_addr[1:0] == 2'b00 && $countones(pci_addr[31:11]) == 1));
    // Aborted reads return all ones.
    p_abort_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && pci_done && pci_mabort) |=> (lb_rdata == ALL_ONES));
endmodule

// File: rtl/cfg_port_seq.sv
// Top of the configuration port sequencer. With HOST_CFG_EN set it builds the
// register set, the target decoder and the cycle sequencer; otherwise every
// local access reads zero and no PCI transaction is ever requested.
// Assumes: index 0 address port, 1 data port, 2 bus register, 3 unused.
module cfg_port_seq
    import cfg_port_pkg::*;
#(
    parameter int          HOST_CFG_EN = 1,
    parameter int          IDX_W       = 2,
    parameter logic [7:0]  RST_PRI_BUS = 8'd0,
    parameter logic [7:0]  RST_SUB_BUS = 8'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_req,
    input  logic              lb_wr,
    input  logic [IDX_W-1:0]  lb_idx,
    input  logic [31:0]       lb_wdata,
    output logic              lb_ack,
    output logic [31:0]       lb_rdata,
    output logic              pci_req,
    output logic              pci_wr,
    output logic              pci_type1,
    output logic [31:0]       pci_addr,
    output logic [31:0]       pci_wdata,
    input  logic              pci_done,
    input  logic [31:0]       pci_rdata,
    input  logic              pci_mabort
);
    localparam int ADDR_IDX = 0;
    localparam int DATA_IDX = 1;
    localparam int BUS_IDX  = 2;

    generate
        if (HOST_CFG_EN != 0) begin : g_host
            cfg_addr_t    cur_addr;
            cfg_addr_t    wr_fields;
            logic [7:0]   pri_bus;
            logic [7:0]   sub_bus;
            logic         err_flag;
            logic         reg_wr;
            logic         err_set;
            logic [DW-1:0] reg_rdata;
            logic [DW-1:0] tgt_addr;
            tgt_kind_t    kind;

            assign wr_fields = {lb_wdata[31], lb_wdata[23:2]};

            cfg_port_regs #(
                .IDX_W(IDX_W), .RST_PRI(RST_PRI_BUS), .RST_SUB(RST_SUB_BUS),
                .ADDR_IDX(ADDR_IDX), .BUS_IDX(BUS_IDX)
            ) u_regs (
                .clk(clk), .rst_n(rst_n),
                .wr_en(reg_wr), .wr_idx(lb_idx), .wr_fields(wr_fields),
                .wr_pri(lb_wdata[7:0]), .wr_sub(lb_wdata[15:8]), .wr_clr(lb_wdata[16]),
                .err_set(err_set), .rd_idx(lb_idx), .rd_data(reg_rdata),
                .cur_addr(cur_addr), .pri_bus(pri_bus), .sub_bus(sub_bus),
                .err_flag(err_flag)
            );

            cfg_target_decode u_dec (
                .cur(cur_addr), .pri_bus(pri_bus), .sub_bus(sub_bus),
                .kind(kind), .tgt_addr(tgt_addr)
            );

            cfg_cycle_fsm #(.IDX_W(IDX_W), .DATA_IDX(DATA_IDX)) u_fsm (
                .clk(clk), .rst_n(rst_n),
                .lb_req(lb_req), .lb_wr(lb_wr), .lb_idx(lb_idx), .lb_wdata(lb_wdata),
                .lb_ack(lb_ack), .lb_rdata(lb_rdata),
                .kind(kind), .tgt_addr(tgt_addr), .reg_rdata(reg_rdata),
                .reg_wr(reg_wr), .err_set(err_set),
                .pci_req(pci_req), .pci_wr(pci_wr), .pci_type1(pci_type1),
                .pci_addr(pci_addr), .pci_wdata(pci_wdata),
                .pci_done(pci_done), .pci_rdata(pci_rdata), .pci_mabort(pci_mabort)
            );

            // A transaction only starts while the address port is enabled.
            p_enabled_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pci_req) |-> cur_addr.en);
            // An abort completion leaves the error flag set.
            p_abort_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (pci_req && pci_done && pci_mabort) |=> err_flag);
        end else begin : g_none
            // Without host configuration support: acknowledge everything with zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lb_ack   <= 1'b0;
                    lb_rdata <= '0;
                end else begin
                    lb_ack   <= lb_req && !lb_ack;
                    lb_rdata <= '0;
                end
            end
            assign pci_req   = 1'b0;
            assign pci_wr    = 1'b0;
            assign pci_type1 = 1'b0;
            assign pci_addr  = '0;
            assign pci_wdata = '0;

            // No transaction ever starts in this variant.
            p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
                !pci_req);
        end
    endgenerate
endmodule

// File: tb/sim_cfg_port_seq.sv
module sim_cfg_port_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        lb_req = 0, lb_wr = 0;
    logic [1:0]  lb_idx = 0;
    logic [31:0] lb_wdata = 0;
    logic        lb_ack;
    logic [31:0] lb_rdata;
    logic        pci_req, pci_wr, pci_type1;
    logic [31:0] pci_addr, pci_wdata;
    logic        pci_done = 0, pci_mabort = 0;
    logic [31:0] pci_rdata = 0;

    logic        v_req = 0, v_wr = 0;
    logic [1:0]  v_idx = 0;
    logic [31:0] v_wdata = 0;
    logic        v_ack, v_preq, v_pwr, v_pt1;
    logic [31:0] v_rdata, v_paddr, v_pwdata;

    cfg_port_seq u0 (
        .clk(clk), .rst_n(rst_n), .lb_req(lb_req), .lb_wr(lb_wr), .lb_idx(lb_idx),
        .lb_wdata(lb_wdata), .lb_ack(lb_ack), .lb_rdata(lb_rdata),
        .pci_req(pci_req), .pci_wr(pci_wr), .pci_type1(pci_type1),
        .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_done(pci_done),
        .pci_rdata(pci_rdata), .pci_mabort(pci_mabort));

    cfg_port_seq #(.HOST_CFG_EN(0)) u1 (
        .clk(clk), .rst_n(rst_n), .lb_req(v_req), .lb_wr(v_wr), .lb_idx(v_idx),
        .lb_wdata(v_wdata), .lb_ack(v_ack), .lb_rdata(v_rdata),
        .pci_req(v_preq), .pci_wr(v_pwr), .pci_type1(v_pt1),
        .pci_addr(v_paddr), .pci_wdata(v_pwdata), .pci_done(1'b0),
        .pci_rdata(32'h0), .pci_mabort(1'b0));

    int errors = 0;
    int checks = 0;

    // Transaction engine model: fixed latency, then one-cycle completion.
    int          lat_next = 0;
    logic [31:0] rd_next = 0;
    logic        ab_next = 0;
    bit          busy = 0;
    int          wait_cnt = 0;
    int          nreq = 0;
    logic [31:0] cap_addr = 0, cap_wd = 0;
    logic        cap_t1 = 0, cap_wr = 0;

    always @(negedge clk) begin
        if (pci_done) begin
            pci_done   <= 1'b0;
            pci_mabort <= 1'b0;
        end else if (pci_req) begin
            if (!busy) begin
                busy = 1; wait_cnt = lat_next; nreq++;
                cap_addr = pci_addr; cap_wd = pci_wdata; cap_t1 = pci_type1; cap_wr = pci_wr;
            end
            if (wait_cnt == 0) begin
                pci_done <= 1'b1; pci_rdata <= rd_next; pci_mabort <= ab_next; busy = 0;
            end else wait_cnt--;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic lb_do(input bit wr, input logic [1:0] idx, input logic [31:0] wd,
                         output logic [31:0] rd, output int cyc);
        @(negedge clk);
        lb_req = 1; lb_wr = wr; lb_idx = idx; lb_wdata = wd; cyc = 0;
        do begin @(posedge clk); @(negedge clk); cyc++; end while (!lb_ack && cyc < 200);
        rd = lb_rdata; lb_req = 0;
    endtask

    // Expected kind: 0 off, 1 type-0, 2 type-1, 3 local abort.
    function automatic int exp_kind(logic [31:0] a, logic [7:0] pri, logic [7:0] sub);
        if (!a[31]) return 0;
        if (a[23:16] == pri) return (a[15:11] > 5'd20) ? 3 : 1;
        if (a[23:16] > pri && a[23:16] <= sub) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] exp_paddr(logic [31:0] a, logic [7:0] pri);
        if (a[23:16] == pri)
            return (32'd1 << (11 + int'(a[15:11]))) | {21'b0, a[10:8], a[7:2], 2'b00};
        return {8'h00, a[23:16], a[15:11], a[10:8], a[7:2], 2'b01};
    endfunction

    // One data-port access with a full comparison against the expected outcome.
    task automatic data_access(input logic [31:0] areg, input bit wr, input logic [31:0] wd,
                               input int lat, input bit ab, input logic [31:0] rdv,
                               inout bit exp_err, input string tag);
        logic [31:0] rd; int cyc; int k; int n0;
        k = exp_kind(areg, 8'd3, 8'd7);
        lat_next = lat; ab_next = ab; rd_next = rdv; n0 = nreq;
        lb_do(wr, 2'd1, wd, rd, cyc);
        if (k == 1 || k == 2) begin
            chk(nreq == n0 + 1, tag, "one PCI request", nreq, n0 + 1);
            chk(cap_addr == exp_paddr(areg, 8'd3), tag, "address phase", cap_addr, exp_paddr(areg, 8'd3));
            chk(cap_t1 == (k == 2), tag, "cycle type", cap_t1, (k == 2));
            chk(cap_wr == wr, "R9", "direction", cap_wr, wr);
            if (wr) chk(cap_wd == wd, "R9", "write data", cap_wd, wd);
            chk(cyc == 2 + lat, "R8", "ack latency", cyc, 2 + lat);
            if (!wr) chk(rd == (ab ? 32'hFFFF_FFFF : rdv), ab ? "R10" : "R8", "read data", rd,
                         ab ? 32'hFFFF_FFFF : rdv);
            if (ab) exp_err = 1;
        end else begin
            chk(nreq == n0, (k == 0) ? "R4" : "R7", "no PCI request", nreq, n0);
            chk(cyc == 1, (k == 0) ? "R4" : "R7", "local ack latency", cyc, 1);
            if (!wr) chk(rd == 32'hFFFF_FFFF, (k == 0) ? "R4" : "R7", "local read data", rd, 32'hFFFF_FFFF);
            if (k == 3) exp_err = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired (R8 stall)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd; int cyc; bit e; logic [31:0] a;
        void'($urandom(32'd20240611));
        e = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pci_req == 0 && lb_ack == 0, "R1", "idle outputs", {pci_req, lb_ack}, 0);
        rst_n = 1;
        lb_do(0, 2'd0, 0, rd, cyc); chk(rd == 0, "R1", "address port reset", rd, 0);
        lb_do(0, 2'd2, 0, rd, cyc); chk(rd == 0, "R1", "bus register reset", rd, 0);

        lb_do(1, 2'd0, 32'hFFFF_FFFF, rd, cyc); chk(cyc == 1, "R2", "write ack latency", cyc, 1);
        lb_do(0, 2'd0, 0, rd, cyc); chk(rd == 32'h80FF_FFFC, "R2", "masked read back", rd, 32'h80FF_FFFC);
        lb_do(0, 2'd3, 0, rd, cyc); chk(rd == 0 && cyc == 1, "R2", "unused index", rd, 0);

        lb_do(1, 2'd2, 32'h0000_0703, rd, cyc);
        lb_do(0, 2'd2, 0, rd, cyc); chk(rd == 32'h0000_0703, "R3", "bus numbers", rd, 32'h703);

        a = 32'h0003_0800; lb_do(1, 2'd0, a, rd, cyc);
        data_access(a, 0, 0, 0, 0, 0, e, "R4");
        data_access(a, 1, 32'h55, 0, 0, 0, e, "R4");

        a = 32'h8003_A5FC; lb_do(1, 2'd0, a, rd, cyc);     // own bus, device 20
        data_access(a, 0, 0, 3, 0, 32'h1234_5678, e, "R5");

        a = 32'h8003_A800; lb_do(1, 2'd0, a, rd, cyc);     // own bus, device 21
        data_access(a, 0, 0, 0, 0, 0, e, "R7");
        lb_do(0, 2'd2, 0, rd, cyc); chk(rd[16] == 1, "R7", "error flag set", rd, 32'h1_0703);
        lb_do(1, 2'd2, 32'h0001_0703, rd, cyc);
        lb_do(0, 2'd2, 0, rd, cyc); chk(rd == 32'h0000_0703, "R3", "error flag cleared", rd, 32'h703);
        e = 0;

        a = 32'h8007_FF7C; lb_do(1, 2'd0, a, rd, cyc);     // subordinate bus edge
        data_access(a, 1, 32'hCAFE_F00D, 0, 0, 0, e, "R6");
        a = 32'h8008_0000; lb_do(1, 2'd0, a, rd, cyc);
        data_access(a, 0, 0, 0, 0, 0, e, "R7");
        a = 32'h8002_0000; lb_do(1, 2'd0, a, rd, cyc);
        data_access(a, 0, 0, 0, 0, 0, e, "R7");
        lb_do(1, 2'd2, 32'h0001_0703, rd, cyc); e = 0;

        a = 32'h8005_1104; lb_do(1, 2'd0, a, rd, cyc);
        data_access(a, 0, 0, 4, 1, 32'h0BAD_0BAD, e, "R10");
        lb_do(0, 2'd2, 0, rd, cyc); chk(rd[16] == 1, "R10", "abort sets flag", rd, 32'h1_0703);
        lb_do(1, 2'd2, 32'h0001_0703, rd, cyc); e = 0;

        for (int i = 0; i < 80; i++) begin
            logic [7:0] bus; int sel;
            sel = int'($urandom % 4);
            case (sel)
                0: bus = 8'd3;
                1: bus = 8'(4 + $urandom % 4);
                2: bus = 8'($urandom);
                default: bus = 8'd8;
            endcase
            a = {($urandom % 10) != 0, 7'b0, bus, 5'($urandom), 3'($urandom), 6'($urandom), 2'b00};
            lb_do(1, 2'd0, a, rd, cyc);
            data_access(a, 1'($urandom), $urandom, int'($urandom % 6), ($urandom % 5) == 0,
                        $urandom, e, "R11");
            if (i % 8 == 7) begin
                lb_do(0, 2'd2, 0, rd, cyc);
                chk(rd == {15'b0, e, 16'h0703}, "R3", "random error flag", rd, {15'b0, e, 16'h0703});
                lb_do(1, 2'd2, 32'h0001_0703, rd, cyc); e = 0;
            end
        end

        for (int j = 0; j < 4; j++) begin
            int c; c = 0;
            @(negedge clk); v_req = 1; v_wr = (j == 0); v_idx = 2'(j); v_wdata = 32'h8000_0000;
            do begin @(posedge clk); @(negedge clk); c++; end while (!v_ack && c < 20);
            chk(c == 1 && v_rdata == 0, "R12", "absent register read", v_rdata, 0);
            v_req = 0;
        end
        chk(v_preq == 0, "R12", "no request when absent", v_preq, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule